// File: doc/BRIEF.md
# Windowed Transaction Budget Regulator

This block sits on the address-request channel between a set of requesters and a shared memory interconnect. For each requester it passes the valid/ready handshake straight through while that requester still has budget in the current time window. Once the requester's number of accepted requests in the window reaches its programmed limit, the block holds the request back by forcing the downstream valid and the upstream ready low. The hold lasts until a new window begins. This reserves a share of memory bandwidth for each requester.

A free-running window timer defines windows of a programmable number of clock cycles, and every per-requester count starts again from zero at each window boundary. A small memory-mapped register port lets a supervisor program the window length and the per-requester limits at runtime. Newly written values are staged and only become active at the next window boundary. Through the same port the supervisor reads, for each requester, the number of requests accepted in the last complete window. Arbitration among the requests that are let through, and the data channels, lie outside this block.

Top module: `wbr_top`

## Requirements
- R1: While a requester is under its limit, its `dn_valid` equals its `up_valid` and its `up_ready` equals its `dn_ready`, in the same cycle.
- R2: A request is counted only in a cycle where `up_valid`, `dn_ready` and the requester's permission are all high. A request presented while `dn_ready` is low is not counted.
- R3: Once a requester has had as many requests accepted in the current window as its active limit allows, its `dn_valid` and `up_ready` stay low for the rest of that window. A requester with limit h and k cycles of continuous demand gets min(h, k) acceptances in a window.
- R4: A limit of zero blocks the requester for the whole window: `dn_valid` and `up_ready` are never high.
- R5: A window lasts exactly the active period in cycles. The first window starts in the first cycle after reset. Counts restart at every boundary. The count register of requester i (address 0x20 + 4*i) shows the acceptances of the last complete window, updated at its boundary.
- R6: A write to the period (address 0x00) or to the limit of requester i (address 0x04 + 4*i) during a window does not change behaviour in that window. It takes effect from the next window. A read of these addresses returns the value last written.
- R7: The count registers are read-only, and writes to them change nothing. Reads of addresses that are not mapped return zero. Registers are 32-bit words on 4-byte aligned addresses.
- R8: Synchronous reset, active high, sets the period to `DEF_PERIOD`, every limit to `DEF_THR`, and all counts to zero. It also restarts the window timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | N_REQ | Request valid from each requester |
| up_ready | output | N_REQ | Ready back to each requester |
| dn_valid | output | N_REQ | Request valid towards the interconnect |
| dn_ready | input | N_REQ | Ready from the interconnect, per requester |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, shared by read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |

## Verification
Suppose a requester's counter or its staged limit is wrong. The result shows up within one window as the wrong number of accepted handshakes at `dn_valid`/`dn_ready`. It also shows up one cycle after the boundary as a wrong count value at the read port. A timer fault moves the cycle in which a blocked requester gets its first grant of the new window. The bench therefore records the exact cycle of each grant, including across a change of period. If a staged value were applied too early, the grant count would change within the window in which the value was written. The bench checks that window separately from the one that follows it.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    // word offsets (byte address / 4)
    localparam int WORD_PERIOD = 0;
    localparam int WORD_THR    = 1;
    localparam int WORD_CNT    = 8;

    typedef logic [REG_AW-3:0] widx_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PERIOD,
        SEL_THR,
        SEL_CNT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        widx_t    idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [REG_AW-1:0] a, input int n);
        reg_dec_t d;
        int       w;
        d.sel = SEL_NONE;
        d.idx = '0;
        w     = int'(a[REG_AW-1:2]);
        if (a[1:0] == 2'b00) begin
            if (w == WORD_PERIOD) begin
                d.sel = SEL_PERIOD;
            end else if (w >= WORD_THR && w < WORD_THR + n) begin
                d.sel = SEL_THR;
                d.idx = widx_t'(w - WORD_THR);
            end else if (w >= WORD_CNT && w < WORD_CNT + n) begin
                d.sel = SEL_CNT;
                d.idx = widx_t'(w - WORD_CNT);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/wbr_regs.sv
module wbr_regs
    import wbr_pkg::*;
#(
    parameter int N_REQ      = 4,
    parameter int CNT_W      = 16,
    parameter int PER_W      = 32,
    parameter int DEF_PERIOD = 64,
    parameter int DEF_THR    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [REG_AW-1:0]            addr,
    input  logic [REG_DW-1:0]            wdata,
    input  logic [N_REQ-1:0][CNT_W-1:0]  last_cnt,
    output logic [PER_W-1:0]             shd_period,
    output logic [N_REQ-1:0][CNT_W-1:0]  shd_thr,
    output logic [REG_DW-1:0]            rdata
);

    reg_dec_t dec;
    assign dec = decode_addr(addr, N_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_period <= PER_W'(DEF_PERIOD);
            for (int i = 0; i < N_REQ; i++) shd_thr[i] <= CNT_W'(DEF_THR);
        end else if (we) begin
            if (dec.sel == SEL_PERIOD) shd_period <= wdata[PER_W-1:0];
            for (int i = 0; i < N_REQ; i++) begin
                if (dec.sel == SEL_THR && int'(dec.idx) == i) shd_thr[i] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (dec.sel)
            SEL_PERIOD: rdata[PER_W-1:0] = shd_period;
            SEL_THR: begin
                for (int i = 0; i < N_REQ; i++)
                    if (int'(dec.idx) == i) rdata[CNT_W-1:0] = shd_thr[i];
            end
            SEL_CNT: begin
                for (int i = 0; i < N_REQ; i++)
                    if (int'(dec.idx) == i) rdata[CNT_W-1:0] = last_cnt[i];
            end
            default: rdata = '0;
        endcase
    end

    // R7
    cnt_region_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (we && dec.sel == SEL_CNT) |=> ($stable(shd_thr) && $stable(shd_period)));

endmodule

// File: rtl/wbr_window.sv
module wbr_window #(
    parameter int PER_W      = 32,
    parameter int DEF_PERIOD = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] shd_period,
    output logic             wend
);

    logic [PER_W-1:0] tmr;
    logic [PER_W-1:0] act_period;

    // last cycle of the window; a period of 0 or 1 gives one-cycle windows
    assign wend = (tmr + 1'b1) >= act_period;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr        <= '0;
            act_period <= PER_W'(DEF_PERIOD);
        end else if (wend) begin
            tmr        <= '0;
            act_period <= shd_period;
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    // R5
    tmr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (act_period == '0) || (tmr < act_period));

    // R6
    period_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wend |=> $stable(act_period));

endmodule

// File: rtl/wbr_budget.sv
module wbr_budget #(
    parameter int CNT_W   = 16,
    parameter int DEF_THR = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wend,
    input  logic [CNT_W-1:0] shd_thr,
    input  logic             up_valid,
    output logic             up_ready,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [CNT_W-1:0] last_cnt
);

    logic [CNT_W-1:0] act_thr;
    logic [CNT_W-1:0] cnt;
    logic             allow;
    logic             hs;

    assign allow    = cnt < act_thr;
    assign dn_valid = up_valid & allow;
    assign up_ready = dn_ready & allow;
    assign hs       = up_valid & dn_ready & allow;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_thr  <= CNT_W'(DEF_THR);
            cnt      <= '0;
            last_cnt <= '0;
        end else if (wend) begin
            act_thr  <= shd_thr;
            last_cnt <= cnt + CNT_W'(hs);
            cnt      <= '0;
        end else if (hs) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    cnt_le_thr_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= act_thr);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hs && !wend) |=> (cnt == $past(cnt) + 1'b1));

    // R5
    win_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wend |=> (cnt == '0));

    // R5
    last_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wend |=> $stable(last_cnt));

    // R4
    zero_thr_block_chk: assert property (@(posedge clk) disable iff (rst)
        (act_thr == '0) |-> (!dn_valid && !up_ready));

endmodule

// File: rtl/wbr_top.sv
module wbr_top
    import wbr_pkg::*;
#(
    parameter int N_REQ      = 4,
    parameter int CNT_W      = 16,
    parameter int PER_W      = 32,
    parameter int DEF_PERIOD = 64,
    parameter int DEF_THR    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_REQ-1:0]  up_valid,
    output logic [N_REQ-1:0]  up_ready,
    output logic [N_REQ-1:0]  dn_valid,
    input  logic [N_REQ-1:0]  dn_ready,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata
);

    logic                        wend;
    logic [PER_W-1:0]            shd_period;
    logic [N_REQ-1:0][CNT_W-1:0] shd_thr;
    logic [N_REQ-1:0][CNT_W-1:0] last_cnt;

    wbr_regs #(
        .N_REQ(N_REQ), .CNT_W(CNT_W), .PER_W(PER_W),
        .DEF_PERIOD(DEF_PERIOD), .DEF_THR(DEF_THR)
    ) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .last_cnt(last_cnt), .shd_period(shd_period), .shd_thr(shd_thr),
        .rdata(reg_rdata)
    );

    wbr_window #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_window (
        .clk(clk), .rst(rst), .shd_period(shd_period), .wend(wend)
    );

    for (genvar i = 0; i < N_REQ; i++) begin : g_req
        wbr_budget #(.CNT_W(CNT_W), .DEF_THR(DEF_THR)) u_budget (
            .clk(clk), .rst(rst), .wend(wend), .shd_thr(shd_thr[i]),
            .up_valid(up_valid[i]), .up_ready(up_ready[i]),
            .dn_valid(dn_valid[i]), .dn_ready(dn_ready[i]),
            .last_cnt(last_cnt[i])
        );
    end

endmodule

// File: tb/tb_wbr_top.sv
`timescale 1ns/1ps
module tb_wbr_top;

    localparam int N  = 4;
    localparam int P  = 16;
    localparam int H0 = 3;

    typedef struct packed {
        logic [1:0]  idx;
        logic [15:0] h;
        logic [7:0]  k;
        logic        rdy;
    } vec_t;

    // requester, limit, cycles of demand, downstream ready
    localparam vec_t TBL [8] = '{
        '{2'd0, 16'd3,  8'd16, 1'b1},
        '{2'd1, 16'd5,  8'd4,  1'b1},
        '{2'd2, 16'd0,  8'd16, 1'b1},
        '{2'd3, 16'd2,  8'd16, 1'b0},
        '{2'd0, 16'd16, 8'd16, 1'b1},
        '{2'd1, 16'd1,  8'd16, 1'b1},
        '{2'd2, 16'd7,  8'd7,  1'b1},
        '{2'd3, 16'd4,  8'd10, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [N-1:0] up_valid, up_ready, dn_valid, dn_ready;
    logic         reg_we;
    logic [7:0]   reg_addr;
    logic [31:0]  reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;
    int ncyc;

    wbr_top #(.N_REQ(N), .DEF_PERIOD(P), .DEF_THR(H0)) dut (
        .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic align();
        while (ncyc % P != 0) step();
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          ng, nr, g;
        up_valid  = '0;
        dn_ready  = '0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        @(negedge clk);
        rst = 1'b1;
        step(); step();
        rst = 1'b0;

        // R8 reset values
        rd(8'h00, d); check("R8 period reset", d, P);
        rd(8'h04, d); check("R8 limit reset", d, H0);
        rd(8'h20, d); check("R8 count reset", d, 0);

        // R1 pass-through under budget
        up_valid[2] = 1'b1; dn_ready[2] = 1'b0; #1;
        check("R1 dn_valid follows", 32'(dn_valid[2]), 1);
        check("R1 up_ready follows low", 32'(up_ready[2]), 0);
        step();
        dn_ready[2] = 1'b1; #1;
        check("R1 up_ready follows high", 32'(up_ready[2]), 1);
        step();
        up_valid = '0; dn_ready = '0;

        // table walk: R2 R3 R4 R5
        for (int e = 0; e < 8; e++) begin
            vec_t  v;
            int    exp_n;
            string tag;
            v = TBL[e];
            align();
            wr(8'(4 + 4 * int'(v.idx)), 32'(v.h));
            align();
            ng = 0; nr = 0;
            for (int c = 0; c < P; c++) begin
                up_valid[v.idx] = (c < int'(v.k));
                dn_ready[v.idx] = v.rdy;
                #1;
                if (up_valid[v.idx] && dn_valid[v.idx] && dn_ready[v.idx]) ng++;
                if (up_ready[v.idx]) nr++;
                step();
            end
            up_valid = '0; dn_ready = '0;
            exp_n = v.rdy ? ((int'(v.h) < int'(v.k)) ? int'(v.h) : int'(v.k)) : 0;
            if (v.h == 0)      tag = "R4 grants";
            else if (!v.rdy)   tag = "R2 grants";
            else               tag = "R3 grants";
            check(tag, ng, exp_n);
            if (v.h == 0) check("R4 up_ready never high", nr, 0);
            rd(8'(8'h20 + 4 * int'(v.idx)), d);
            check("R5 last window count", d, exp_n);
        end

        // R6 limit written mid-window applies from the next window
        align();
        wr(8'h04, 1);
        align();
        ng = 0; nr = 0;
        up_valid[0] = 1'b1; dn_ready[0] = 1'b1;
        for (int c = 0; c < 2 * P; c++) begin
            if (c == 2) begin
                reg_we = 1'b1; reg_addr = 8'h04; reg_wdata = 3;
            end else begin
                reg_we = 1'b0;
            end
            #1;
            if (dn_valid[0]) begin
                if (c < P) ng++;
                else       nr++;
            end
            step();
        end
        reg_we = 1'b0;
        up_valid = '0; dn_ready = '0;
        check("R6 old limit kept in window", ng, 1);
        check("R6 new limit next window", nr, 3);
        rd(8'h04, d); check("R6 limit read-back", d, 3);

        // R5/R6 period change mid-window; requester 1 has limit 1
        align();
        g = 0;
        up_valid[1] = 1'b1; dn_ready[1] = 1'b1;
        for (int c = 0; c < 40; c++) begin
            if (c == 3) begin
                reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 8;
            end else begin
                reg_we = 1'b0;
            end
            #1;
            if (dn_valid[1]) g++;
            if (c == 0 || c == 16 || c == 24 || c == 32)
                check("R5 grant at window start", 32'(dn_valid[1]), 1);
            step();
        end
        reg_we = 1'b0;
        up_valid = '0; dn_ready = '0;
        check("R6 period change grant count", g, 4);
        rd(8'h00, d); check("R6 period read-back", d, 8);

        // R8 reset during activity
        up_valid = '1; dn_ready = '1;
        rst = 1'b1;
        step(); step();
        up_valid = '0; dn_ready = '0;
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin
            rd(8'(8'h20 + 4 * i), d); check("R8 count cleared", d, 0);
        end
        rd(8'h00, d); check("R8 period restored", d, P);
        for (int i = 0; i < N; i++) begin
            rd(8'(4 + 4 * i), d); check("R8 limit restored", d, H0);
        end

        // R7 map: read-only counts, unmapped reads zero
        wr(8'h24, 32'h55);
        rd(8'h24, d); check("R7 count write ignored", d, 0);
        rd(8'h04, d); check("R7 limit untouched", d, H0);
        rd(8'h40, d); check("R7 unmapped reads zero", d, 0);
        rd(8'h14, d); check("R7 gap reads zero", d, 0);
        rd(8'h06, d); check("R7 unaligned reads zero", d, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule